// File: doc/BRIEF.md
# Coalescing Line-Wide Write Buffer

This block sits between a core and a write-through cache level. It holds pending stores until they are sent to the next level. Each slot covers one whole cache line and keeps a valid bit for every word. A narrow scalar store and a full-line vector store therefore use the same slot format. A store to a line that is already held merges into that slot instead of taking a new one.

Slots leave through a drain port with a valid/ready handshake. They leave oldest first, but only once the occupancy reaches half the depth. A load probe compares one line address per cycle against the held lines, so a vector access that covers two lines takes two probe cycles. When every requested word of the probed line is present, the line is returned at once. When the line is held but words are missing, the requester is told to wait. In both cases that slot is drained next, ahead of older slots.

Top module: `coalesce_wbuf`

## Requirements
- R1: A store to a line that is not held, accepted while fewer than DEPTH slots are in use, takes a new slot. The slot holds the line address, the masked words and the mask. Word i sits at bits [i*WORD_W +: WORD_W], and mask bit i covers word i.
- R2: A store to a held line writes only its masked words into that slot and ORs its mask into the slot mask. The other words keep their values, and no new slot is used.
- R3: Without load matches, slots drain in the order in which their lines were first allocated.
- R4: Draining starts when occupancy is at least DEPTH/2 (4 for DEPTH 8). Below that level, and with no load match, dr_valid stays 0.
- R5: A probe whose line is held with every requested word valid raises ld_hit in the same cycle, and ld_data carries the merged line.
- R6: A probe whose line is held but lacks a requested word raises ld_wait and keeps ld_hit at 0.
- R7: A probe that matches a held line (hit or wait) makes that slot the next one drained, even below the threshold and ahead of older slots.
- R8: When all slots are in use, a store to a line that is not held sees st_ready = 0. A store that merges is still accepted.
- R9: dr_valid, dr_addr, dr_data and dr_mask hold steady until dr_ready is seen. A store to the line being presented sees st_ready = 0.
- R10: A merging store and a drain pop in the same cycle both take effect: the merged words are kept, and occupancy drops by one.
- R11: After reset the buffer is empty: dr_valid, ld_hit and ld_wait are 0 and st_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | Store request |
| st_ready | output | 1 | Store accepted this cycle |
| st_addr | input | ADDR_W | Store line address |
| st_data | input | WORDS*WORD_W | Store line data |
| st_mask | input | WORDS | Store word enables |
| ld_valid | input | 1 | Load probe request |
| ld_addr | input | ADDR_W | Probe line address |
| ld_mask | input | WORDS | Words the load needs |
| ld_hit | output | 1 | Bypass data valid |
| ld_wait | output | 1 | Line held but incomplete |
| ld_data | output | WORDS*WORD_W | Bypassed line |
| dr_valid | output | 1 | Drain line presented |
| dr_ready | input | 1 | Next level accepts drain |
| dr_addr | output | ADDR_W | Drained line address |
| dr_data | output | WORDS*WORD_W | Drained line data |
| dr_mask | output | WORDS | Drained word valids |

## Verification
Two functions can act in the same cycle: a store that merges into a younger slot, and the pop of an older slot that shifts the younger one down. The bench holds a drain back with dr_ready low. It then raises dr_ready in the very cycle it sends a partial store to a younger held line. The merged line is then probed and must match the word-by-word merge. The drain scoreboard, which must see the popped line exactly once, confirms that the pop took effect.

// File: rtl/wb_pkg.sv
package wb_pkg;
  // Why a drain is being started in a given cycle.
  typedef enum logic [1:0] {
    DR_IDLE   = 2'd0,
    DR_FORCED = 2'd1,
    DR_LEVEL  = 2'd2
  } drain_src_e;
endpackage

// File: rtl/wb_tag_match.sv
module wb_tag_match #(
  parameter int N  = 8,
  parameter int AW = 16
) (
  input  logic [N-1:0][AW-1:0] tags,
  input  logic [N-1:0]         live,
  input  logic [AW-1:0]        key,
  output logic [N-1:0]         hit
);
  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign hit[i] = live[i] && (tags[i] == key);
  end
endmodule

// File: rtl/wb_first_set.sv
module wb_first_set #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/coalesce_wbuf.sv
module coalesce_wbuf
  import wb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int WORD_W = 32,
  parameter int WORDS  = 4,
  parameter int DEPTH  = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     st_valid,
  output logic                     st_ready,
  input  logic [ADDR_W-1:0]        st_addr,
  input  logic [WORDS*WORD_W-1:0]  st_data,
  input  logic [WORDS-1:0]         st_mask,
  input  logic                     ld_valid,
  input  logic [ADDR_W-1:0]        ld_addr,
  input  logic [WORDS-1:0]         ld_mask,
  output logic                     ld_hit,
  output logic                     ld_wait,
  output logic [WORDS*WORD_W-1:0]  ld_data,
  output logic                     dr_valid,
  input  logic                     dr_ready,
  output logic [ADDR_W-1:0]        dr_addr,
  output logic [WORDS*WORD_W-1:0]  dr_data,
  output logic [WORDS-1:0]         dr_mask
);
  localparam int IDX_W  = $clog2(DEPTH);
  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam int THRESH = DEPTH / 2;

  typedef logic [WORDS-1:0][WORD_W-1:0] line_t;

  // Slot state; slot 0 is always the oldest line.
  logic [DEPTH-1:0][ADDR_W-1:0] tag_q,  tag_d,  t_tag;
  line_t [DEPTH-1:0]            line_q, line_d, t_line;
  logic [DEPTH-1:0][WORDS-1:0]  wm_q,   wm_d,   t_wm;
  logic [DEPTH-1:0]             urg_q,  urg_d,  t_urg, urg_now;
  logic [CNT_W-1:0]             cnt_q,  cnt_d;
  logic                         dr_act_q, dr_act_d;
  logic [IDX_W-1:0]             dr_idx_q, dr_idx_d;

  logic [DEPTH-1:0] live, st_hitv, ld_hitv;
  logic             st_any, ld_any, u_any;
  logic [IDX_W-1:0] st_idx, ld_idx, u_idx, wr_idx, start_idx;
  logic             full, lock_hit, st_fire, alloc, pop, start, ld_cover;
  logic             arr_en, urg_en, cnt_en, ctl_en;
  drain_src_e       src;
  line_t            st_words;

  assign st_words = st_data;

  for (genvar i = 0; i < DEPTH; i++) begin : g_live
    assign live[i] = (CNT_W'(i) < cnt_q);
  end

  wb_tag_match #(.N(DEPTH), .AW(ADDR_W)) u_st_match (
    .tags(tag_q), .live(live), .key(st_addr), .hit(st_hitv));
  wb_tag_match #(.N(DEPTH), .AW(ADDR_W)) u_ld_match (
    .tags(tag_q), .live(live), .key(ld_addr), .hit(ld_hitv));

  wb_first_set #(.N(DEPTH), .IW(IDX_W)) u_st_pick (
    .req(st_hitv), .any(st_any), .idx(st_idx));
  wb_first_set #(.N(DEPTH), .IW(IDX_W)) u_ld_pick (
    .req(ld_hitv), .any(ld_any), .idx(ld_idx));
  wb_first_set #(.N(DEPTH), .IW(IDX_W)) u_urg_pick (
    .req(urg_now), .any(u_any), .idx(u_idx));

  // Store acceptance
  assign full     = (cnt_q == CNT_W'(DEPTH));
  assign lock_hit = dr_act_q && st_any && (st_idx == dr_idx_q);
  assign st_ready = !lock_hit && (st_any || !full);
  assign st_fire  = st_valid && st_ready;
  assign alloc    = st_fire && !st_any;
  assign wr_idx   = st_any ? st_idx : cnt_q[IDX_W-1:0];

  // Load probe and bypass
  assign ld_cover = ((ld_mask & ~wm_q[ld_idx]) == '0);
  assign ld_hit   = ld_valid && ld_any && ld_cover;
  assign ld_wait  = ld_valid && ld_any && !ld_cover;
  assign ld_data  = ld_any ? line_q[ld_idx] : '0;
  assign urg_now  = urg_q | (ld_valid ? ld_hitv : '0);

  // Drain port
  assign dr_valid = dr_act_q;
  assign dr_addr  = tag_q[dr_idx_q];
  assign dr_data  = line_q[dr_idx_q];
  assign dr_mask  = wm_q[dr_idx_q];
  assign pop      = dr_act_q && dr_ready;

  always_comb begin
    src = DR_IDLE;
    if (!dr_act_q) begin
      if (u_any)                         src = DR_FORCED;
      else if (cnt_q >= CNT_W'(THRESH))  src = DR_LEVEL;
    end
  end
  assign start     = (src != DR_IDLE);
  assign start_idx = (src == DR_FORCED) ? u_idx : '0;

  // Next state: apply the store, then close the gap left by a pop.
  always_comb begin
    t_tag  = tag_q;
    t_line = line_q;
    t_wm   = wm_q;
    t_urg  = urg_now;
    if (st_fire) begin
      t_tag[wr_idx] = st_addr;
      for (int w = 0; w < WORDS; w++) begin
        if (st_mask[w]) t_line[wr_idx][w] = st_words[w];
      end
      t_wm[wr_idx] = (st_any ? wm_q[wr_idx] : '0) | st_mask;
      if (!st_any) t_urg[wr_idx] = 1'b0;
    end
    tag_d  = t_tag;
    line_d = t_line;
    wm_d   = t_wm;
    urg_d  = t_urg;
    if (pop) begin
      for (int i = 0; i < DEPTH - 1; i++) begin
        if (i >= int'(dr_idx_q)) begin
          tag_d[i]  = t_tag[i+1];
          line_d[i] = t_line[i+1];
          wm_d[i]   = t_wm[i+1];
          urg_d[i]  = t_urg[i+1];
        end
      end
      wm_d[DEPTH-1]  = '0;
      urg_d[DEPTH-1] = 1'b0;
    end
    cnt_d    = cnt_q + CNT_W'(alloc) - CNT_W'(pop);
    dr_act_d = pop ? 1'b0 : (start ? 1'b1 : dr_act_q);
    dr_idx_d = start ? start_idx : dr_idx_q;
  end

  assign arr_en = st_fire || pop;
  assign urg_en = st_fire || pop || ld_valid;
  assign cnt_en = alloc || pop;
  assign ctl_en = start || pop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      urg_q    <= '0;
      dr_act_q <= 1'b0;
      dr_idx_q <= '0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      if (urg_en) urg_q <= urg_d;
      if (ctl_en) begin
        dr_act_q <= dr_act_d;
        dr_idx_q <= dr_idx_d;
      end
    end
  end

  // Payload storage: only slots below cnt_q are ever read.
  always_ff @(posedge clk) begin
    if (arr_en) begin
      tag_q  <= tag_d;
      line_q <= line_d;
      wm_q   <= wm_d;
    end
  end
endmodule

// File: rtl/wb_chk.sv
module wb_chk #(
  parameter int ADDR_W = 16,
  parameter int WORD_W = 32,
  parameter int WORDS  = 4,
  parameter int DEPTH  = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    st_valid,
  input logic                    st_ready,
  input logic                    ld_valid,
  input logic [ADDR_W-1:0]       ld_addr,
  input logic                    ld_hit,
  input logic                    ld_wait,
  input logic                    dr_valid,
  input logic                    dr_ready,
  input logic [ADDR_W-1:0]       dr_addr,
  input logic [WORDS*WORD_W-1:0] dr_data,
  input logic [WORDS-1:0]        dr_mask,
  input logic [$clog2(DEPTH+1)-1:0] cnt
);
  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam int THRESH = DEPTH / 2;

  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(DEPTH));

  a_r9_drain_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (dr_valid && !dr_ready) |=> (dr_valid && $stable(dr_addr)
                                 && $stable(dr_data) && $stable(dr_mask)));

  a_r4_level_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!dr_valid && cnt >= CNT_W'(THRESH)) |=> dr_valid);

  a_r7_probe_forces: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && (ld_hit || ld_wait) && !dr_valid)
      |=> (dr_valid && dr_addr == $past(ld_addr)));

  a_r6_hit_or_wait: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld_hit && ld_wait));

  a_r10_pop_count: assert property (@(posedge clk) disable iff (!rst_n)
    (dr_valid && dr_ready && !(st_valid && st_ready))
      |=> (cnt == $past(cnt) - CNT_W'(1)));
endmodule

bind coalesce_wbuf wb_chk #(
  .ADDR_W(ADDR_W), .WORD_W(WORD_W), .WORDS(WORDS), .DEPTH(DEPTH)
) u_wb_chk (
  .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
  .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_hit(ld_hit), .ld_wait(ld_wait),
  .dr_valid(dr_valid), .dr_ready(dr_ready), .dr_addr(dr_addr),
  .dr_data(dr_data), .dr_mask(dr_mask), .cnt(cnt_q)
);

// File: tb/coalesce_wbuf_tb_top.sv
`timescale 1ns/1ps
module coalesce_wbuf_tb_top;
  localparam int AW = 16;
  localparam int WW = 32;
  localparam int NW = 4;
  localparam int DP = 8;
  localparam int LW = WW * NW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          st_valid, st_ready;
  logic [AW-1:0] st_addr;
  logic [LW-1:0] st_data;
  logic [NW-1:0] st_mask;
  logic          ld_valid, ld_hit, ld_wait;
  logic [AW-1:0] ld_addr;
  logic [NW-1:0] ld_mask;
  logic [LW-1:0] ld_data;
  logic          dr_valid, dr_ready;
  logic [AW-1:0] dr_addr;
  logic [LW-1:0] dr_data;
  logic [NW-1:0] dr_mask;

  always #2 clk = ~clk;

  coalesce_wbuf #(.ADDR_W(AW), .WORD_W(WW), .WORDS(NW), .DEPTH(DP)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr),
    .st_data(st_data), .st_mask(st_mask),
    .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_mask(ld_mask),
    .ld_hit(ld_hit), .ld_wait(ld_wait), .ld_data(ld_data),
    .dr_valid(dr_valid), .dr_ready(dr_ready), .dr_addr(dr_addr),
    .dr_data(dr_data), .dr_mask(dr_mask));

  typedef struct {
    logic [AW-1:0] addr;
    logic [LW-1:0] data;
    logic [NW-1:0] mask;
    string         req;
  } exp_t;
  exp_t exp_q[$];

  int n_checks = 0;
  int n_fail   = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [LW-1:0] act, input logic [LW-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [LW-1:0] mk(input int s);
    logic [LW-1:0] v;
    for (int i = 0; i < NW; i++) v[i*WW +: WW] = WW'(s * 256 + i);
    return v;
  endfunction

  function automatic logic [LW-1:0] wexp(input logic [NW-1:0] m);
    logic [LW-1:0] v;
    for (int i = 0; i < NW; i++) v[i*WW +: WW] = {WW{m[i]}};
    return v;
  endfunction

  function automatic logic [LW-1:0] mrg(input logic [LW-1:0] b,
                                        input logic [LW-1:0] u,
                                        input logic [NW-1:0] m);
    return (b & ~wexp(m)) | (u & wexp(m));
  endfunction

  function automatic void expect_drain(input logic [AW-1:0] a,
                                       input logic [LW-1:0] d,
                                       input logic [NW-1:0] m,
                                       input string r);
    exp_t e;
    e.addr = a; e.data = d; e.mask = m; e.req = r;
    exp_q.push_back(e);
  endfunction

  // Monitor: scoreboard pop on every accepted drain, sampled mid-cycle.
  always @(negedge clk) begin
    if (rst_n && dr_valid && dr_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R3", "unexpected drain addr", LW'(dr_addr), '0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(dr_addr == e.addr, e.req, "drain addr", LW'(dr_addr), LW'(e.addr));
        chk(dr_mask == e.mask, e.req, "drain mask", LW'(dr_mask), LW'(e.mask));
        chk((dr_data & wexp(e.mask)) == (e.data & wexp(e.mask)), e.req,
            "drain data", dr_data & wexp(e.mask), e.data & wexp(e.mask));
      end
    end
  end

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic idle(input int n);
    repeat (n) cyc();
  endtask

  task automatic store(input logic [AW-1:0] a, input logic [LW-1:0] d,
                       input logic [NW-1:0] m, input string r);
    int guard;
    guard = 0;
    st_valid = 1'b1; st_addr = a; st_data = d; st_mask = m;
    @(negedge clk);
    while (!st_ready && guard < 50) begin
      guard++;
      @(negedge clk);
    end
    chk(st_ready, r, "store accepted", LW'(st_ready), LW'(1));
    cyc();
    st_valid = 1'b0;
  endtask

  task automatic probe(input logic [AW-1:0] a, input logic [NW-1:0] m,
                       input bit eh, input bit ew, input logic [LW-1:0] ed,
                       input string r);
    ld_valid = 1'b1; ld_addr = a; ld_mask = m;
    @(negedge clk);
    chk(ld_hit == eh, r, "ld_hit", LW'(ld_hit), LW'(eh));
    chk(ld_wait == ew, r, "ld_wait", LW'(ld_wait), LW'(ew));
    if (eh) chk((ld_data & wexp(m)) == (ed & wexp(m)), r, "ld_data",
                ld_data & wexp(m), ed & wexp(m));
    cyc();
    ld_valid = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures",
             n_checks, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL R3 watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  localparam logic [AW-1:0] A = 16'h0100, B = 16'h0110, C = 16'h0120,
                            D = 16'h0130, E = 16'h0140, F = 16'h0150,
                            G = 16'h0160, H = 16'h0170, I = 16'h0180,
                            J = 16'h0190, K = 16'h01a0, L = 16'h01b0,
                            M = 16'h01c0, N = 16'h01d0, P = 16'h01e0;

  initial begin
    rst_n = 1'b0; st_valid = 1'b0; st_addr = '0; st_data = '0; st_mask = '0;
    ld_valid = 1'b0; ld_addr = '0; ld_mask = '0; dr_ready = 1'b1;
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R11: empty after reset
    chk(st_ready == 1'b1, "R11", "st_ready", LW'(st_ready), LW'(1));
    chk(dr_valid == 1'b0, "R11", "dr_valid", LW'(dr_valid), '0);
    chk(ld_hit == 1'b0 && ld_wait == 1'b0, "R11", "ld flags",
        LW'({ld_hit, ld_wait}), '0);
    cyc();

    // R1 / R2: allocate then merge, R4: single slot stays put
    store(A, mk(1), 4'b0011, "R1");
    store(A, mk(2), 4'b0100, "R2");
    idle(4);
    @(negedge clk);
    chk(dr_valid == 1'b0, "R4", "no drain below level", LW'(dr_valid), '0);
    cyc();
    // R5: full-coverage probe bypasses merged line; R7 forces its drain
    expect_drain(A, mrg(mk(1), mk(2), 4'b0100), 4'b0111, "R2");
    probe(A, 4'b0111, 1'b1, 1'b0, mrg(mk(1), mk(2), 4'b0100), "R5");
    idle(4);

    // R3 / R4: threshold drain, oldest first, stops below level
    store(B, mk(3), 4'b1111, "R1");
    store(C, mk(4), 4'b1111, "R1");
    store(D, mk(5), 4'b0101, "R1");
    idle(4);
    @(negedge clk);
    chk(dr_valid == 1'b0, "R4", "three slots no drain", LW'(dr_valid), '0);
    cyc();
    expect_drain(B, mk(3), 4'b1111, "R3");
    store(E, mk(6), 4'b1111, "R4");
    idle(6);
    @(negedge clk);
    chk(dr_valid == 1'b0, "R4", "drain stops at three", LW'(dr_valid), '0);
    cyc();
    expect_drain(C, mk(4), 4'b1111, "R3");
    store(F, mk(7), 4'b1111, "R4");
    idle(4);

    // R7: younger F jumps ahead of D and E
    expect_drain(F, mk(7), 4'b1111, "R7");
    probe(F, 4'b1111, 1'b1, 1'b0, mk(7), "R7");
    idle(4);
    // R6: D lacks word 1
    expect_drain(D, mk(5), 4'b0101, "R6");
    probe(D, 4'b0010, 1'b0, 1'b1, '0, "R6");
    idle(4);

    // R8 / R9: fill with drain held back
    dr_ready = 1'b0;
    store(G, mk(10), 4'b1111, "R1");
    store(H, mk(11), 4'b1111, "R1");
    store(I, mk(12), 4'b1111, "R1");
    store(J, mk(13), 4'b1111, "R1");
    store(K, mk(14), 4'b1111, "R1");
    store(L, mk(15), 4'b1111, "R1");
    store(M, mk(16), 4'b1111, "R1");
    st_valid = 1'b1; st_addr = N; st_data = mk(18); st_mask = 4'b1111;
    @(negedge clk);
    chk(st_ready == 1'b0, "R8", "new line stalls when full", LW'(st_ready), '0);
    cyc();
    st_valid = 1'b0;
    store(H, mk(20), 4'b0001, "R8");
    st_valid = 1'b1; st_addr = E; st_data = mk(21); st_mask = 4'b1111;
    @(negedge clk);
    chk(st_ready == 1'b0, "R9", "store to presented line", LW'(st_ready), '0);
    chk(dr_valid == 1'b1 && dr_addr == E, "R9", "presented addr",
        LW'(dr_addr), LW'(E));
    cyc();
    st_valid = 1'b0;
    idle(3);
    @(negedge clk);
    chk(dr_valid == 1'b1 && dr_addr == E && dr_data == mk(6), "R9",
        "held payload", dr_data, mk(6));
    cyc();
    expect_drain(E, mk(6), 4'b1111, "R9");
    expect_drain(G, mk(10), 4'b1111, "R3");
    expect_drain(H, mrg(mk(11), mk(20), 4'b0001), 4'b1111, "R2");
    expect_drain(I, mk(12), 4'b1111, "R3");
    expect_drain(J, mk(13), 4'b1111, "R3");
    dr_ready = 1'b1;
    idle(20);
    @(negedge clk);
    chk(dr_valid == 1'b0, "R4", "stops after five", LW'(dr_valid), '0);
    cyc();

    // R10: merge into M in the same cycle K pops
    dr_ready = 1'b0;
    store(P, mk(17), 4'b1111, "R1");
    idle(2);
    @(negedge clk);
    chk(dr_valid == 1'b1 && dr_addr == K, "R10", "K presented",
        LW'(dr_addr), LW'(K));
    cyc();
    expect_drain(K, mk(14), 4'b1111, "R10");
    dr_ready = 1'b1;
    st_valid = 1'b1; st_addr = M; st_data = mk(30); st_mask = 4'b1000;
    @(negedge clk);
    chk(st_ready == 1'b1, "R10", "merge beside pop", LW'(st_ready), LW'(1));
    cyc();
    st_valid = 1'b0;
    idle(2);
    @(negedge clk);
    chk(dr_valid == 1'b0, "R10", "three left after pop", LW'(dr_valid), '0);
    cyc();
    expect_drain(M, mrg(mk(16), mk(30), 4'b1000), 4'b1111, "R10");
    probe(M, 4'b1111, 1'b1, 1'b0, mrg(mk(16), mk(30), 4'b1000), "R10");
    idle(4);
    expect_drain(L, mk(15), 4'b1111, "R7");
    probe(L, 4'b1111, 1'b1, 1'b0, mk(15), "R5");
    idle(4);
    expect_drain(P, mk(17), 4'b1111, "R7");
    probe(P, 4'b0001, 1'b1, 1'b0, mk(17), "R5");
    idle(6);
    chk(exp_q.size() == 0, "R3", "all expected drains seen",
        LW'(exp_q.size()), '0);
    summary();
    $finish;
  end
endmodule